// File: doc/BRIEF.md
# External Clock Fail Monitor

This block guards a system that runs from an external clock. A slow reference clock that never stops (about 125 kHz) drives a small timeout counter. Every rising edge of the external clock marks activity. That activity crosses into the reference domain and clears the counter. If the counter reaches its trip value, the external clock is taken as lost. The block then raises a sticky fail flag and forces the clock-select output to the internal fast RC source (value 0).

Firmware sets the enable bit to turn monitoring on. It reads the fail flag and clears it with a one-cycle clear strobe. Its own choice of clock source goes in on `sel_req` and comes out, possibly overridden, on `sel_out`. The trip count is a parameter. The default of 13 reference periods gives about 104 µs, so the external clock must run at about 10 kHz or faster.

Top module: `ext_clk_monitor`

## Requirements
- R1: After reset, `fail_flag` is 0, the timeout counter is 0 and `sel_out` equals `sel_req`.
- R2: While enabled, an external clock whose period is at most 11 reference periods never sets `fail_flag`, because each of its rising edges clears the counter.
- R3: While enabled, if no external activity is seen for `TRIP_CYCLES` (default 13) consecutive reference edges, `fail_flag` goes to 1 on the following reference edge. Started with a stopped external clock, the flag is 0 after the 13th edge and 1 after the 14th. The counter saturates at the trip value and does not wrap.
- R4: An external clock whose period is 16 or more reference periods (for example 5 kHz) sets `fail_flag`.
- R5: `fail_flag` is sticky. It stays 1 when the external clock resumes and when `mon_en` falls.
- R6: A one-cycle pulse on `fail_clr` clears `fail_flag` and the counter. If the external clock is still stopped, the flag returns `TRIP_CYCLES`+1 edges later.
- R7: While `mon_en` is 0, the counter is held at 0 and `fail_flag` cannot be set, however long the external clock stays stopped.
- R8: `sel_out` is `sel_req` while `fail_flag` is 0, and 0 while `fail_flag` is 1.
- R9: Once the external clock has stopped while monitoring is enabled, `fail_flag` is 1 within 25 reference periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Slow reference clock that is always running |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Monitor enable control bit |
| ext_clk | input | 1 | External clock being watched |
| fail_clr | input | 1 | Clear strobe for the fail flag (write-one-to-clear) |
| sel_req | input | 1 | Requested clock select (1 = external) |
| fail_flag | output | 1 | Sticky external-clock-fail status |
| sel_out | output | 1 | Effective clock select, forced to 0 on failure |

## Verification
The hardest cases to reach are at the timing edges: the exact edge on which the trip fires, and external periods near the trip count, where the synchronizer latency decides the outcome. To pin down the exact edge, the bench enables the monitor with the external clock already stopped long enough for the synchronizer to settle. It then counts reference edges from the enable. The bench also sweeps the external period across the range in reference periods. It leaves out a guard band around the trip value and computes the expected outcome from the period alone.

// File: rtl/ext_clk_monitor.sv
module ext_clk_monitor #(
  parameter int TRIP_CYCLES = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic ext_clk,
  input  logic fail_clr,
  input  logic sel_req,
  output logic fail_flag,
  output logic sel_out
);
  localparam int CW = $clog2(TRIP_CYCLES + 1);
  localparam logic [CW-1:0] TRIP = CW'(TRIP_CYCLES);

  logic                   ext_tog;
  logic [SYNC_STAGES:0]   sync_q;
  logic                   activity;
  logic [CW-1:0]          cnt;

  always_ff @(posedge ext_clk or negedge rst_n)
    if (!rst_n) ext_tog <= 1'b0;
    else        ext_tog <= ~ext_tog;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_tog};

  assign activity = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)                          cnt <= '0;
    else if (!mon_en || fail_clr || activity) cnt <= '0;
    else if (cnt != TRIP)                cnt <= cnt + 1'b1;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)                      fail_flag <= 1'b0;
    else if (fail_clr)               fail_flag <= 1'b0;
    else if (mon_en && cnt == TRIP)  fail_flag <= 1'b1;

  assign sel_out = sel_req & ~fail_flag;

  AST_CNT_NO_WRAP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cnt <= TRIP); // R3
  AST_TRIP_SETS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mon_en && cnt == TRIP && !fail_clr) |=> fail_flag); // R3
  AST_FLAG_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_flag && !fail_clr) |=> fail_flag); // R5
  AST_CLR_WORKS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_clr |=> (!fail_flag && cnt == '0)); // R6
  AST_DIS_HOLD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !mon_en |=> (cnt == '0 && !$rose(fail_flag))); // R7
  AST_OVERRIDE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_flag |-> !sel_out); // R8
endmodule

// File: tb/ext_clk_monitor_test.sv
`timescale 1ns/1ps
module ext_clk_monitor_test;
  logic ref_clk = 0, rst_n = 0, mon_en = 0, ext_clk = 0, fail_clr = 0, sel_req = 0;
  logic fail_flag, sel_out;
  logic ext_run = 0;
  int   ext_half = 50;
  int   tests = 0, fails = 0;
  int   cyc = 0;

  ext_clk_monitor uut (.ref_clk(ref_clk), .rst_n(rst_n), .mon_en(mon_en), .ext_clk(ext_clk),
    .fail_clr(fail_clr), .sel_req(sel_req), .fail_flag(fail_flag), .sel_out(sel_out));

  always #5 ref_clk = ~ref_clk;

  always begin
    if (ext_run) begin #(ext_half); ext_clk = ~ext_clk; end
    else #1;
  end

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung, expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    fail_clr = 1; wait_edges(1); fail_clr = 0;
  endtask

  initial begin
    sel_req = 1;
    #23;
    check("R1 flag", fail_flag, 1'b0);
    check("R1 sel", sel_out, 1'b1);
    rst_n = 1;
    wait_edges(3);
    check("R1 after release", fail_flag, 1'b0);

    // R7: disabled, clock stopped for long time
    wait_edges(60);
    check("R7 disabled no fail", fail_flag, 1'b0);
    check("R8 sel follows req", sel_out, 1'b1);

    // R3: exact trip timing from enable with stopped clock
    mon_en = 1;
    wait_edges(13);
    check("R3 not yet at 13", fail_flag, 1'b0);
    wait_edges(1);
    check("R3 set at 14", fail_flag, 1'b1);
    check("R8 override", sel_out, 1'b0);
    sel_req = 0; wait_edges(1);
    check("R8 req0", sel_out, 1'b0);
    sel_req = 1;

    // R5: sticky on disable and clock resume
    mon_en = 0; wait_edges(5);
    check("R5 sticky on disable", fail_flag, 1'b1);
    mon_en = 1; ext_half = 15; ext_run = 1; wait_edges(40);
    check("R5 sticky on resume", fail_flag, 1'b1);

    // R6: clear with running clock stays clear
    pulse_clr();
    check("R6 cleared", fail_flag, 1'b0);
    check("R8 sel restored", sel_out, 1'b1);
    wait_edges(50);
    check("R2 running 3-period clock", fail_flag, 1'b0);

    // R9: stop clock while enabled
    ext_run = 0;
    wait_edges(10);
    check("R9 not early", fail_flag, 1'b0);
    wait_edges(15);
    check("R9 stopped clock fails", fail_flag, 1'b1);

    // R6: clear with clock still stopped -> returns after 14 edges
    pulse_clr();
    check("R6 cleared stopped", fail_flag, 1'b0);
    wait_edges(12);
    check("R6 not before rearm", fail_flag, 1'b0);
    wait_edges(2);
    check("R6 returns", fail_flag, 1'b1);

    // R7: disable and clear, clock stopped
    mon_en = 0; pulse_clr(); wait_edges(80);
    check("R7 disabled after clear", fail_flag, 1'b0);

    // R2/R4 sweep of external period in reference periods
    mon_en = 1;
    for (int p = 2; p <= 26; p++) begin
      if (p >= 12 && p <= 15) continue;
      ext_half = p * 5;
      ext_run = 1;
      wait_edges(3 * p + 6);
      pulse_clr();
      wait_edges(40 * p);
      check(p <= 11 ? "R2 sweep fast clock" : "R4 sweep slow clock", fail_flag, p >= 16);
      ext_run = 0;
      wait_edges(2 * p);
    end

    // named cases: 50 kHz (2.5 periods) and 5 kHz (25 periods)
    ext_half = 12; ext_run = 1; wait_edges(10); pulse_clr(); wait_edges(500);
    check("R2 50kHz no fail", fail_flag, 1'b0);
    ext_run = 0; ext_half = 125; ext_run = 1; wait_edges(60); pulse_clr(); wait_edges(600);
    check("R4 5kHz fails", fail_flag, 1'b1);
    ext_run = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule